// File: doc/BRIEF.md
# Sequential 8x8 Cosine Transform Engine

This block computes the two-dimensional cosine transform of an 8x8 block of signed integers as two matrix products: an intermediate matrix T = C·f, then the result F = T·Cᵀ. A single multiplier and a single adder do all the work. A nine-bit step counter drives the engine. The counter splits into three three-bit loop indices: row, column and inner term. Each sum of eight products is built in an accumulator and then written back into an internal 256-word register file.

The register file holds four regions, each 64 words long. The cosine coefficients are loaded into region 0 at reset and are never overwritten. The loaded input goes into region 1, the intermediate matrix into region 2 and the result into region 3. The transposed coefficient matrix is never stored. The engine reads it from the same coefficient region with the two indices swapped. Coefficients are integers scaled by 256, so the final sums are shifted right arithmetically by 16 bits.

To use the block, pulse `start` while the engine is idle and then present the 64 input words, one per clock. The results later appear on `dout` with `out_valid`, and a one-cycle `done` marks the end of the frame.

Top module: `dct8_engine`

## Requirements
- R1: While reset is held and just after it, `out_valid` and `done` are low and `dout` is zero.
- R2: The 64 input words are taken from `din` in row-major order, element (r,c) at index 8·r+c, on the 64 clock edges that follow the edge where `start` is sampled high. `din` is ignored at all other times.
- R3: Each result is F[i][j] = (Σk T[i][k]·C[j][k]) >>> 16, where T[i][j] = Σk C[i][k]·f[k][j]. All arithmetic is 32-bit two's complement and the shift is arithmetic (it rounds toward minus infinity). The coefficients are C[0][k] = 91 and C[i][k] = round(128·cos((2k+1)·i·π/16)) for i > 0.
- R4: The first result appears with `out_valid` high 1089 clock edges after the `start` edge. Exactly 64 results then follow on consecutive cycles in row-major order.
- R5: `done` is high for exactly one cycle, the cycle right after the last result (1153 edges after the `start` edge). It is never high together with `out_valid`.
- R6: A `start` pulse that arrives while the engine is not idle has no effect. Result order, values and timing of the running frame stay unchanged, and no extra frame begins.
- R7: The coefficient region is never written, so frames that run one after another all use the same coefficients.
- R8: `dout` reads zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a frame when the engine is idle |
| din | input | 32 | Input matrix element, signed |
| done | output | 1 | One-cycle end-of-frame pulse |
| dout | output | 32 | Result element, signed, zero when not valid |
| out_valid | output | 1 | Output enable: high while results are presented |

## Verification
Some properties are checked on every cycle by assertions:
- `done` lasts one cycle and follows directly after the output window.
- The step counter advances by one or clears.
- Writebacks never land back to back.
- The coefficient region is never a write target.
- The load path and the accumulator never compete for the write port.

Other behaviour only the bench scenarios can show. These are the transform values themselves for ramp, zero, constant, checkerboard, impulse and mixed-sign inputs, the exact latency to the first result, the row-major order, and rounding toward minus infinity on negative sums. They also include the claim that stray `start` pulses and `din` noise during computation change nothing.

// File: rtl/dct8_pkg.sv
package dct8_pkg;

   typedef enum logic [2:0] {
      ST_IDLE, ST_LOAD, ST_MUL1, ST_MUL2, ST_DRAIN, ST_OUT, ST_FIN
   } dct8_state_e;

   // region tags: top two address bits of the register file
   localparam logic [1:0] RG_COEF = 2'd0;
   localparam logic [1:0] RG_IN   = 2'd1;
   localparam logic [1:0] RG_MID  = 2'd2;
   localparam logic [1:0] RG_RES  = 2'd3;

   // magnitude of 128*cos(m*pi/16) for m = 0..8
   function automatic int cos_mag(int m);
      case (m)
         0: return 128;
         1: return 126;
         2: return 118;
         3: return 106;
         4: return 91;
         5: return 71;
         6: return 49;
         7: return 25;
         default: return 0;
      endcase
   endfunction

   // coefficient for row r, column c, scaled by 2^8
   function automatic int coef_at(int r, int c);
      int m;
      if (r == 0) return 91;
      m = ((2 * c + 1) * r) % 32;
      if (m <= 8)       return cos_mag(m);
      else if (m <= 16) return -cos_mag(16 - m);
      else if (m <= 24) return -cos_mag(m - 16);
      else              return cos_mag(32 - m);
   endfunction

endpackage

// File: rtl/dct8_loop_ctr.sv
module dct8_loop_ctr #(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [IDX_W-1:0] idx_i,
   output logic [IDX_W-1:0] idx_j,
   output logic [IDX_W-1:0] idx_k
);
   localparam int CW = 3 * IDX_W;

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign idx_i = cnt_q[CW-1 -: IDX_W];
   assign idx_j = cnt_q[2*IDX_W-1 -: IDX_W];
   assign idx_k = cnt_q[IDX_W-1:0];

   // R3
   step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !clr) |=> cnt_q == $past(cnt_q) + 1'b1);

   // R3
   clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt_q == '0);

endmodule

// File: rtl/dct8_regfile.sv
module dct8_regfile
   import dct8_pkg::*;
#(
   parameter int DW    = 32,
   parameter int IDX_W = 3
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ren_a,
   input  logic [2+2*IDX_W-1:0]    raddr_a,
   output logic [DW-1:0]           rdata_a,
   input  logic                    ren_b,
   input  logic [2+2*IDX_W-1:0]    raddr_b,
   output logic [DW-1:0]           rdata_b,
   input  logic                    we,
   input  logic [2+2*IDX_W-1:0]    waddr,
   input  logic [DW-1:0]           wdata
);
   localparam int AW     = 2 + 2 * IDX_W;
   localparam int DEPTH  = 1 << AW;
   localparam int REGION = 1 << (2 * IDX_W);
   localparam int NPT    = 1 << IDX_W;

   logic [DW-1:0] mem [DEPTH];
   logic          ren_v   [2];
   logic [AW-1:0] raddr_v [2];
   logic [DW-1:0] rdata_v [2];

   // coefficient region reloads on reset and is read-only afterwards
   always_ff @(posedge clk) begin
      for (int a = 0; a < DEPTH; a++) begin
         if (!rst_n)
            mem[a] <= (a < REGION) ? DW'(coef_at(a / NPT, a % NPT)) : '0;
         else if (we && (int'(waddr) == a) && (a >= REGION))
            mem[a] <= wdata;
      end
   end

   assign ren_v[0]   = ren_a;
   assign ren_v[1]   = ren_b;
   assign raddr_v[0] = raddr_a;
   assign raddr_v[1] = raddr_b;

   for (genvar p = 0; p < 2; p++) begin : g_rport
      assign rdata_v[p] = ren_v[p] ? mem[raddr_v[p]] : '0;
   end

   assign rdata_a = rdata_v[0];
   assign rdata_b = rdata_v[1];

   // R7
   coef_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> waddr[AW-1 -: 2] != RG_COEF);

endmodule

// File: rtl/dct8_mac.sv
module dct8_mac #(
   parameter int DW    = 32,
   parameter int AW    = 8,
   parameter int SHIFT = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          issue,
   input  logic          first,
   input  logic          last,
   input  logic          shift_en,
   input  logic [AW-1:0] dst,
   input  logic [DW-1:0] op_a,
   input  logic [DW-1:0] op_b,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [DW-1:0] wr_data
);
   logic signed [2*DW-1:0] ax, bx, full;
   logic signed [DW-1:0]   prod_q, sum_q, acc_next;
   logic                   prod_v, first_q, last_q, shift_q;
   logic [AW-1:0]          dst_q;

   assign ax   = {{DW{op_a[DW-1]}}, op_a};
   assign bx   = {{DW{op_b[DW-1]}}, op_b};
   assign full = ax * bx;

   // product register stage with its tags
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prod_q  <= '0;
         prod_v  <= 1'b0;
         first_q <= 1'b0;
         last_q  <= 1'b0;
         shift_q <= 1'b0;
         dst_q   <= '0;
      end else begin
         prod_v <= issue;
         if (issue) begin
            prod_q  <= full[DW-1:0];
            first_q <= first;
            last_q  <= last;
            shift_q <= shift_en;
            dst_q   <= dst;
         end
      end
   end

   assign acc_next = first_q ? prod_q : sum_q + prod_q;

   // sum register: cleared by reset, loaded on every valid product
   always_ff @(posedge clk) begin
      if (!rst_n)      sum_q <= '0;
      else if (prod_v) sum_q <= acc_next;
   end

   assign wr_en   = prod_v && last_q;
   assign wr_addr = dst_q;
   assign wr_data = shift_q ? (acc_next >>> SHIFT) : acc_next;

   // R3
   wb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en);

endmodule

// File: rtl/dct8_ctrl.sv
module dct8_ctrl
   import dct8_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [IDX_W-1:0]     idx_i,
   input  logic [IDX_W-1:0]     idx_j,
   input  logic [IDX_W-1:0]     idx_k,
   output logic                 inc,
   output logic                 clr,
   output logic                 ld_we,
   output logic [2+2*IDX_W-1:0] ld_addr,
   output logic                 ren_a,
   output logic                 ren_b,
   output logic [2+2*IDX_W-1:0] raddr_a,
   output logic [2+2*IDX_W-1:0] raddr_b,
   output logic                 issue,
   output logic                 first,
   output logic                 last,
   output logic                 shift_en,
   output logic [2+2*IDX_W-1:0] dst,
   output logic                 oe,
   output logic                 done
);
   dct8_state_e state_q, state_d;
   logic        row_end, sweep_end;

   assign row_end   = &{idx_j, idx_k};
   assign sweep_end = &{idx_i, idx_j, idx_k};
   assign first     = (idx_k == '0);
   assign last      = &idx_k;
   assign ld_addr   = {RG_IN, idx_j, idx_k};

   always_ff @(posedge clk) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_comb begin
      state_d  = state_q;
      inc      = 1'b0;
      clr      = 1'b0;
      ld_we    = 1'b0;
      ren_a    = 1'b0;
      ren_b    = 1'b0;
      raddr_a  = '0;
      raddr_b  = '0;
      issue    = 1'b0;
      shift_en = 1'b0;
      dst      = '0;
      oe       = 1'b0;
      done     = 1'b0;
      case (state_q)
         ST_IDLE: if (start) begin
            state_d = ST_LOAD;
            clr     = 1'b1;
         end
         ST_LOAD: begin
            ld_we = 1'b1;
            inc   = 1'b1;
            if (row_end) begin
               state_d = ST_MUL1;
               clr     = 1'b1;
            end
         end
         ST_MUL1: begin
            ren_a   = 1'b1;
            ren_b   = 1'b1;
            issue   = 1'b1;
            inc     = 1'b1;
            raddr_a = {RG_COEF, idx_i, idx_k};
            raddr_b = {RG_IN, idx_k, idx_j};
            dst     = {RG_MID, idx_i, idx_j};
            if (sweep_end) begin
               state_d = ST_MUL2;
               clr     = 1'b1;
            end
         end
         ST_MUL2: begin
            ren_a    = 1'b1;
            ren_b    = 1'b1;
            issue    = 1'b1;
            inc      = 1'b1;
            shift_en = 1'b1;
            raddr_a  = {RG_MID, idx_i, idx_k};
            raddr_b  = {RG_COEF, idx_j, idx_k};
            dst      = {RG_RES, idx_i, idx_j};
            if (sweep_end) begin
               state_d = ST_DRAIN;
               clr     = 1'b1;
            end
         end
         ST_DRAIN: state_d = ST_OUT;
         ST_OUT: begin
            ren_a   = 1'b1;
            oe      = 1'b1;
            inc     = 1'b1;
            raddr_a = {RG_RES, idx_j, idx_k};
            if (row_end) begin
               state_d = ST_FIN;
               clr     = 1'b1;
            end
         end
         ST_FIN: begin
            done    = 1'b1;
            state_d = ST_IDLE;
         end
         default: state_d = ST_IDLE;
      endcase
   end

   // R5
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R5
   done_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(oe) && !oe));

   // R6
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_q != ST_LOAD) |=> state_q != ST_LOAD);

endmodule

// File: rtl/dct8_engine.sv
module dct8_engine #(
   parameter int DW        = 32,
   parameter int IDX_W     = 3,
   parameter int COEF_FRAC = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [DW-1:0] din,
   output logic          done,
   output logic [DW-1:0] dout,
   output logic          out_valid
);
   localparam int AW    = 2 + 2 * IDX_W;
   localparam int SHIFT = 2 * COEF_FRAC;

   if (IDX_W != 3) begin : g_bad_idx
      $error("coefficient generator covers the 8-point transform only");
   end
   if (COEF_FRAC != 8) begin : g_bad_frac
      $error("coefficient table is scaled by 2^8");
   end
   if (DW < 24) begin : g_bad_dw
      $error("data width too small for the accumulated sums");
   end

   logic [IDX_W-1:0] idx_i, idx_j, idx_k;
   logic             inc, clr, ld_we, ren_a, ren_b, issue, first, last, shift_en, oe;
   logic [AW-1:0]    ld_addr, raddr_a, raddr_b, dst, mac_addr, w_addr;
   logic [DW-1:0]    rdata_a, rdata_b, mac_data, w_data;
   logic             mac_we, w_en;

   dct8_loop_ctr #(.IDX_W(IDX_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc), .clr(clr),
      .idx_i(idx_i), .idx_j(idx_j), .idx_k(idx_k)
   );

   dct8_ctrl #(.IDX_W(IDX_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start),
      .idx_i(idx_i), .idx_j(idx_j), .idx_k(idx_k),
      .inc(inc), .clr(clr), .ld_we(ld_we), .ld_addr(ld_addr),
      .ren_a(ren_a), .ren_b(ren_b), .raddr_a(raddr_a), .raddr_b(raddr_b),
      .issue(issue), .first(first), .last(last), .shift_en(shift_en),
      .dst(dst), .oe(oe), .done(done)
   );

   dct8_mac #(.DW(DW), .AW(AW), .SHIFT(SHIFT)) u_mac (
      .clk(clk), .rst_n(rst_n), .issue(issue), .first(first), .last(last),
      .shift_en(shift_en), .dst(dst), .op_a(rdata_a), .op_b(rdata_b),
      .wr_en(mac_we), .wr_addr(mac_addr), .wr_data(mac_data)
   );

   assign w_en   = ld_we | mac_we;
   assign w_addr = mac_we ? mac_addr : ld_addr;
   assign w_data = mac_we ? mac_data : din;

   dct8_regfile #(.DW(DW), .IDX_W(IDX_W)) u_rf (
      .clk(clk), .rst_n(rst_n),
      .ren_a(ren_a), .raddr_a(raddr_a), .rdata_a(rdata_a),
      .ren_b(ren_b), .raddr_b(raddr_b), .rdata_b(rdata_b),
      .we(w_en), .waddr(w_addr), .wdata(w_data)
   );

   assign out_valid = oe;
   assign dout      = oe ? rdata_a : '0;

   // R2
   port_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(ld_we && mac_we));

endmodule

// File: tb/sim_dct8_engine.sv
`timescale 1ns/1ps
module sim_dct8_engine;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [DW-1:0] din = '0;
   logic          done, out_valid;
   logic [DW-1:0] dout;

   always #2.5 clk = ~clk;

   dct8_engine u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .din(din),
      .done(done), .dout(dout), .out_valid(out_valid)
   );

   int cyc = 0;
   int total = 0;
   int bad = 0;
   int exp_q[$];
   int t0 = 0;
   int nout = 0;
   int frames_done = 0;
   bit wd_hit = 0;
   int e_val;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic int coef(int r, int c);
      if (r == 0) return int'(256.0 / $sqrt(8.0));
      return int'(128.0 * $cos(real'((2 * c + 1) * r) * 3.14159265358979 / 16.0));
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   // driver: pushes expected results, then runs one frame
   task automatic run_frame(input int f[64], input bit disturb);
      int t[64];
      int s;
      int target;
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++) begin
            s = 0;
            for (int k = 0; k < 8; k++) s += coef(i, k) * f[k * 8 + j];
            t[i * 8 + j] = s;
         end
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++) begin
            s = 0;
            for (int k = 0; k < 8; k++) s += t[i * 8 + k] * coef(j, k);
            exp_q.push_back(s >>> 16);
         end
      target = frames_done + 1;
      @(negedge clk);
      start = 1'b1;
      t0 = cyc + 1;
      @(negedge clk);
      start = 1'b0;
      din = f[0];
      for (int n = 1; n < 64; n++) begin
         @(negedge clk);
         din = f[n];
      end
      @(negedge clk);
      din = 32'h1234_5678;  // R2: noise after load must be ignored
      if (disturb) begin
         repeat (100) begin
            @(negedge clk);
            din = $urandom;
         end
         start = 1'b1;  // R6: pulse during first product phase
         @(negedge clk);
         start = 1'b0;
         repeat (600) @(negedge clk);
         start = 1'b1;  // R6: pulse during second product phase
         @(negedge clk);
         start = 1'b0;
         while (!out_valid) @(negedge clk);
         start = 1'b1;  // R6: held during the output window
         repeat (2) @(negedge clk);
         start = 1'b0;
      end
      while (frames_done < target) @(negedge clk);
      @(negedge clk);
   endtask

   // monitor: pops expected items as results appear
   always @(negedge clk) begin
      if (rst_n && !wd_hit) begin
         if (out_valid) begin
            if (nout == 0) check(cyc == t0 + 1089, "R4 first-result latency", cyc - t0, 1089);
            if (exp_q.size() == 0) begin
               check(1'b0, "R4 unexpected result", $signed(dout), 0);
            end else begin
               e_val = exp_q.pop_front();
               check($signed(dout) == e_val, "R3 result value", $signed(dout), e_val);
            end
            nout++;
         end else begin
            check(dout == '0, "R8 dout idle zero", $signed(dout), 0);
         end
         if (done) begin
            check(!out_valid, "R5 done with out_valid", int'(out_valid), 0);
            check(nout == 64, "R4 result count", nout, 64);
            check(cyc == t0 + 1153, "R5 done timing", cyc - t0, 1153);
            nout = 0;
            frames_done++;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      wd_hit = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int f[64];
      int fd;
      repeat (3) @(negedge clk);
      // R1
      check(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      check(done == 1'b0, "R1 reset done", int'(done), 0);
      check(dout == '0, "R1 reset dout", $signed(dout), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(out_valid == 1'b0 && done == 1'b0, "R1 after reset idle", int'(out_valid), 0);

      // R2 R3: ramp in row-major order
      for (int n = 0; n < 64; n++) f[n] = n * 13 - 400;
      run_frame(f, 1'b0);
      // R3: all zero
      for (int n = 0; n < 64; n++) f[n] = 0;
      run_frame(f, 1'b0);
      // R3: constant block
      for (int n = 0; n < 64; n++) f[n] = 100;
      run_frame(f, 1'b0);
      // R6: checkerboard with stray start pulses and din noise
      for (int n = 0; n < 64; n++) f[n] = (((n / 8) + (n % 8)) % 2 == 1) ? 900 : -900;
      run_frame(f, 1'b1);
      // R7: back-to-back frames reuse the coefficients; impulse
      for (int n = 0; n < 64; n++) f[n] = (n == 27) ? 1000 : 0;
      run_frame(f, 1'b0);
      // R3: mixed signs, negative shifts round toward minus infinity
      for (int n = 0; n < 64; n++) f[n] = (((n * 37) % 201) - 100) * 9;
      run_frame(f, 1'b0);

      // R6: no extra frame after the last one
      fd = frames_done;
      repeat (50) @(negedge clk);
      check(frames_done == fd, "R6 no extra frame", frames_done, fd);
      check(exp_q.size() == 0, "R4 all results seen", exp_q.size(), 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule